// File: doc/BRIEF.md
# Oversampled Biphase Line-Cell Recovery

This block recovers the half-bit line cells of a biphase-mark serial stream. It needs no clock locked to the incoming data. A free-running local clock samples the line at about five samples per line cell. At 48 kHz audio with 32-bit subframes, two channels and two cells per bit, that clock runs at 30.72 MHz. The input first passes through a two-stage synchroniser. The logic then locates each level change in the sampled stream and takes the cell value from the sample two positions after the most recent change. When a cell carries no change, the block takes the next cell from the position five samples after the previous one. Every detected change re-anchors the sampling point, so the block absorbs a small rate mismatch between the sample clock and the line.

Recovered cells are shifted into an 8-bit word. The earliest cell of each group lands in the most significant bit. A one-cycle strobe marks each completed word. The strobe serves as the recovered clock for downstream framing logic, such as preamble search and biphase decoding, and may show jitter of a sample period or two. After reset the block stays silent until it has seen the first line transition.

Top module: `biphase_cell_recovery`

## Requirements
- R1: While reset is asserted and immediately after it is released, `cellWord` is all zeros and `wordStrobe` is low.
- R2: After reset, no cell is taken and no strobe occurs until the first level change appears at the output of the two-stage input synchroniser, however long the line stays constant.
- R3: Each level change re-anchors sampling: the cell value is the synchronised line level exactly two sample-clock cycles after the change is detected, and no cell is taken in the cycle the change is detected.
- R4: When no level change occurs, the following cell is taken exactly five sample-clock cycles after the previous one. A run of k equal cells lasting between 5k-2 and 5k+2 samples (k from 1 to 3) therefore yields exactly k cells of that level.
- R5: Cells stretched to six samples or shrunk to four samples are each recovered exactly once, because every level change restarts the spacing.
- R6: Cells are packed eight to a word in arrival order. The first cell of a word is bit 7 and the eighth is bit 0. Word boundaries count from the first cell taken after reset.
- R7: `wordStrobe` is high for exactly one sample-clock cycle per completed word, in the cycle after the eighth cell is taken. `cellWord` changes only in that cycle and holds its value in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sample clock, about five times the line-cell rate |
| rstN | input | 1 | Asynchronous reset, active low |
| serialIn | input | 1 | Asynchronous biphase-mark line input |
| cellWord | output | 8 | Last completed group of eight recovered cells, earliest in bit 7 |
| wordStrobe | output | 1 | One-cycle pulse when `cellWord` is updated (recovered clock) |

## Verification
The bench first holds the line flat after reset, which separates a block that waits for the first change from one that free-runs. Each following pattern targets one way the recovery can go wrong. An alternating single-cell stream at exactly five samples shows whether the two-after-edge sampling point is right. Runs of two and three equal cells at the outer limits of 5k plus or minus 2 expose any error in the five-sample prediction: such an error either drops a cell or takes one twice. Alternating four- and six-sample cells show that each change re-anchors the sampling. A long seeded random mix of run lengths and per-run offsets then checks bit order and word framing over many word boundaries.

// File: rtl/cell_rx_pkg.sv
`timescale 1ns/1ps
package cell_rx_pkg;
  // Strobes sent from the control section to the datapath each sample cycle
  typedef struct packed {
    logic take;      // capture the synchronised line level as the next cell
    logic wordDone;  // this capture completes a word
  } rx_ctrl_t;
endpackage

// File: rtl/cell_rx_datapath.sv
`timescale 1ns/1ps
module cell_rx_datapath
  import cell_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  rx_ctrl_t          ctrl,
  output logic              lineEdge,
  output logic [WORD_W-1:0] cellWord,
  output logic              wordStrobe
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lineLevel;
  logic                   lastLevel;
  logic [WORD_W-1:0]      shiftReg;
  logic [WORD_W-1:0]      nextShift;

  // Synchroniser chain (R2, R3: edges are found on its output)
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= serialIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  assign lineLevel = syncChain[SYNC_STAGES-1];
  assign lineEdge  = lineLevel ^ lastLevel;
  assign nextShift = {shiftReg[WORD_W-2:0], lineLevel};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastLevel <= 1'b0;
    else       lastLevel <= lineLevel;
  end

  // Cell packing, earliest cell ends in the MSB (R6)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      cellWord   <= '0;
      wordStrobe <= 1'b0;
    end else begin
      wordStrobe <= ctrl.wordDone;
      if (ctrl.take) shiftReg <= nextShift;
      if (ctrl.wordDone) cellWord <= nextShift;
    end
  end
endmodule

// File: rtl/cell_rx_control.sv
`timescale 1ns/1ps
module cell_rx_control
  import cell_rx_pkg::*;
#(
  parameter int CELL_SPAN = 5,
  parameter int TAKE_LEAD = 2,
  parameter int WORD_W    = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineEdge,
  output rx_ctrl_t ctrl
);
  localparam int CW = $clog2(CELL_SPAN + 1);
  localparam int BW = $clog2(WORD_W);
  localparam logic [CW-1:0] LEAD_LOAD = CW'(TAKE_LEAD - 1);
  localparam logic [CW-1:0] SPAN_LOAD = CW'(CELL_SPAN - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_W - 1);

  logic          armed;
  logic [CW-1:0] waitCnt;
  logic [BW-1:0] bitCnt;
  logic          takeNow;

  // Take a cell when the countdown expires, never on an edge cycle (R3)
  assign takeNow       = armed && !lineEdge && (waitCnt == '0);
  assign ctrl.take     = takeNow;
  assign ctrl.wordDone = takeNow && (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      waitCnt <= '0;
    end else if (lineEdge) begin
      armed   <= 1'b1;          // R2: first edge arms the recovery
      waitCnt <= LEAD_LOAD;     // R3/R5: re-anchor to this edge
    end else if (takeNow) begin
      waitCnt <= SPAN_LOAD;     // R4: predict the next cell
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (takeNow) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
  end
endmodule

// File: rtl/biphase_cell_recovery.sv
`timescale 1ns/1ps
module biphase_cell_recovery
  import cell_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CELL_SPAN   = 5,
  parameter int TAKE_LEAD   = 2,
  parameter int WORD_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  output logic [WORD_W-1:0] cellWord,
  output logic              wordStrobe
);
  rx_ctrl_t ctrl;
  logic     lineEdge;

  cell_rx_datapath #(.SYNC_STAGES(SYNC_STAGES), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .ctrl(ctrl),
    .lineEdge(lineEdge), .cellWord(cellWord), .wordStrobe(wordStrobe)
  );

  cell_rx_control #(.CELL_SPAN(CELL_SPAN), .TAKE_LEAD(TAKE_LEAD), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineEdge(lineEdge), .ctrl(ctrl)
  );
endmodule

// File: rtl/biphase_cell_recovery_checker.sv
`timescale 1ns/1ps
module biphase_cell_recovery_checker #(
  parameter int CELL_SPAN = 5,
  parameter int WORD_W    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineEdge,
  input logic              take,
  input logic              armed,
  input logic              wordStrobe,
  input logic [WORD_W-1:0] cellWord
);
  logic [7:0] gapCnt;
  logic       haveTake;
  logic       edgeSince;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt    <= '0;
      haveTake  <= 1'b0;
      edgeSince <= 1'b0;
    end else if (take) begin
      gapCnt    <= '0;
      haveTake  <= 1'b1;
      edgeSince <= 1'b0;
    end else begin
      if (gapCnt != 8'hFF) gapCnt <= gapCnt + 1'b1;
      if (lineEdge) edgeSince <= 1'b1;
    end
  end

  a_r2_silent_until_armed: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !wordStrobe);

  a_r3_take_two_after_edge: assert property (@(posedge clk) disable iff (!rstN)
    $past(lineEdge, 2) && !$past(lineEdge) && !lineEdge |-> take);

  a_r4_predicted_spacing: assert property (@(posedge clk) disable iff (!rstN)
    take && haveTake && !edgeSince && !lineEdge |-> gapCnt == 8'(CELL_SPAN - 1));

  a_r6_strobe_after_take: assert property (@(posedge clk) disable iff (!rstN)
    wordStrobe |-> $past(take));

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    wordStrobe |=> !wordStrobe);

  a_r7_word_held: assert property (@(posedge clk) disable iff (!rstN)
    !wordStrobe |-> $stable(cellWord));
endmodule

bind biphase_cell_recovery biphase_cell_recovery_checker #(
  .CELL_SPAN(CELL_SPAN), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rstN(rstN), .lineEdge(lineEdge), .take(ctrl.take),
  .armed(u_ctrl.armed), .wordStrobe(wordStrobe), .cellWord(cellWord)
);

// File: tb/biphase_cell_recovery_bench.sv
`timescale 1ns/1ps
module biphase_cell_recovery_bench;
  localparam int MAXW = 256;

  logic       clk = 1'b0;
  logic       rstN;
  logic       serialIn;
  logic [7:0] cellWord;
  logic       wordStrobe;

  always #10 clk = ~clk;

  biphase_cell_recovery u_biphase_cell_recovery (
    .clk(clk), .rstN(rstN), .serialIn(serialIn),
    .cellWord(cellWord), .wordStrobe(wordStrobe)
  );

  // Expected words, filled by the stimulus ahead of the design
  logic [7:0] expWord [MAXW];
  string      expTag  [MAXW];
  int         wrIdx = 0;
  int         rdIdx = 0;
  logic [7:0] accBits = '0;
  int         accCnt = 0;
  logic       curLvl = 1'b0;

  int mainChecks = 0, mainErrors = 0;
  int monChecks = 0, monErrors = 0;
  int strobeCount = 0;
  logic monOn = 1'b0;
  logic prevStrobe = 1'b0;
  logic heldDirty = 1'b0;
  logic [7:0] heldWord = '0;

  function automatic logic [7:0] packCell(logic [7:0] acc, logic v);
    return {acc[6:0], v};   // R6: earliest cell moves toward bit 7
  endfunction

  task automatic pushCell(input logic v, input string tag);
    accBits = packCell(accBits, v);
    accCnt++;
    if (accCnt == 8) begin
      expWord[wrIdx] = accBits;
      expTag[wrIdx]  = tag;
      wrIdx++;
      accCnt = 0;
    end
  endtask

  task automatic driveLevel(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1 serialIn = lvl;
    end
  endtask

  // One run of k equal cells lasting t samples, starting with a level change
  task automatic lineRun(input int k, input int t, input string tag);
    curLvl = ~curLvl;
    for (int i = 0; i < k; i++) pushCell(curLvl, tag);
    driveLevel(curLvl, t);
  endtask

  always @(negedge clk) begin
    if (monOn) begin
      if (wordStrobe) begin
        strobeCount++;
        monChecks++;
        if (prevStrobe) begin
          monErrors++;
          $display("FAIL R7 strobe width: actual=2+ cycles expected=1");
        end
        monChecks++;
        if (heldDirty) begin
          monErrors++;
          $display("FAIL R7 word changed between strobes: actual=%0h expected=%0h", cellWord, heldWord);
        end
        heldDirty = 1'b0;
        heldWord  = cellWord;
        if (rdIdx < wrIdx) begin
          monChecks++;
          if (cellWord !== expWord[rdIdx]) begin
            monErrors++;
            $display("FAIL %s word %0d: actual=%02h expected=%02h", expTag[rdIdx], rdIdx, cellWord, expWord[rdIdx]);
          end
          rdIdx++;
        end
      end else if (cellWord !== heldWord) begin
        heldDirty = 1'b1;
      end
      prevStrobe = wordStrobe;
    end
  end

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", mainErrors + monErrors + 1, mainChecks + monChecks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rstN = 1'b0;
    serialIn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mainChecks++;
    if (cellWord !== 8'h00 || wordStrobe !== 1'b0) begin
      mainErrors++;
      $display("FAIL R1 in reset: actual=%02h/%0b expected=00/0", cellWord, wordStrobe);
    end
    @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    mainChecks++;
    if (cellWord !== 8'h00 || wordStrobe !== 1'b0) begin
      mainErrors++;
      $display("FAIL R1 after release: actual=%02h/%0b expected=00/0", cellWord, wordStrobe);
    end
    monOn = 1'b1;

    // R2: flat line, nothing may come out
    driveLevel(1'b0, 80);
    mainChecks++;
    if (strobeCount != 0) begin
      mainErrors++;
      $display("FAIL R2 strobes before first edge: actual=%0d expected=0", strobeCount);
    end

    // R3: alternating single cells at nominal length
    for (int i = 0; i < 32; i++) lineRun(1, 5, "R3");

    // R4: runs of two and three equal cells at nominal and extreme lengths
    for (int i = 0; i < 24; i++) begin
      int k = 2 + (i % 2);
      int t = (i % 3 == 0) ? 5 * k - 2 : (i % 3 == 1) ? 5 * k + 2 : 5 * k;
      lineRun(k, t, "R4");
    end

    // R5: stretched and shrunk cells
    for (int i = 0; i < 32; i++) lineRun(1, (i % 2) ? 6 : 4, "R5");
    for (int i = 0; i < 16; i++) lineRun(2, (i % 2) ? 11 : 9, "R5");

    // R6: seeded random mix of run lengths and offsets
    for (int i = 0; i < 320; i++) begin
      int k = 1 + int'($urandom % 3);
      int t = 5 * k + int'($urandom % 5) - 2;
      lineRun(k, t, "R6");
    end

    driveLevel(curLvl, 60);
    mainChecks++;
    if (rdIdx != wrIdx) begin
      mainErrors++;
      $display("FAIL R6 words delivered: actual=%0d expected=%0d", rdIdx, wrIdx);
    end

    $display("Result: errors=%0d of %0d checks", mainErrors + monErrors, mainChecks + monChecks);
    $finish;
  end
endmodule